// File: doc/BRIEF.md
# Vertical Line Pixel Sequencer

This block turns a single request into the pixel coordinates of a vertical line, one coordinate per clock. A one-cycle `start` captures the column, the top row and the line height. From the next cycle on, the block presents that column together with rows that advance downward by one each cycle. It raises `done` on the cycle that carries the final pixel.

A drawing engine pairs this block with a frame-buffer write port. It issues `start` and forwards `x_out`/`y_out` as write addresses for as many cycles as the line is tall. It uses `done` to move to its next primitive. Colour, write enables and clipping at the screen edge belong to the surrounding engine.

Top module: `vline_seq`

## Requirements
- R1: While `reset` is high at a clock edge, and after it, the block is idle with `done` = 0, `x_out` = 0 and `y_out` = 0. A reset in the middle of a line abandons that line.
- R2: When `start` is high at an edge while the block is idle, the next cycle shows the first pixel: `x_out` equals the sampled `x_in` and `y_out` equals the sampled `y_in`.
- R3: `x_out` keeps the latched column for every pixel of the line.
- R4: From one pixel to the next, `y_out` increases by exactly one, with no gap cycles.
- R5: A line of height N (N ≥ 1) lasts exactly N consecutive cycles. `done` is 1 only on the N-th pixel and returns to 0 on the cycle after it. For example, height 6 at column 100, row 50 gives rows 50 to 55.
- R6: A height of 0 behaves like a height of 1: a single pixel, with `done` high in that same cycle.
- R7: `start` has no effect while a line is in progress, including the cycle that carries `done`.
- R8: Rows wrap modulo 256. A line that runs past row 255 continues from row 0.
- R9: Changes on `x_in`, `y_in` or `height` after the start cycle do not alter the line being drawn.
- R10: When a line ends and the block is idle without a new `start`, `x_out` and `y_out` hold the last pixel and `done` stays 0. A `start` in the first idle cycle after `done` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to draw a line; sampled only when idle |
| x_in | input | 9 | Column of the line |
| y_in | input | 8 | Top row of the line |
| height | input | 8 | Line length in pixels; 0 is treated as 1 |
| x_out | output | 9 | Column of the current pixel |
| y_out | output | 8 | Row of the current pixel |
| done | output | 1 | High on the cycle of the final pixel |

## Verification
The bench targets three kinds of fault.

Heights 0 and 1 are tested because a design that counts from the raw height would either run 256 cycles or miss `done` on a single pixel. A line that crosses row 255 catches a design that saturates the row or widens it instead of wrapping.

`start` is pulsed on every cycle of a line, the done cycle included. The inputs are also changed in the middle of a line. A sequencer that re-arms on its own done cycle, or that reads the inputs live instead of latching them, would restart or bend the line.

The bench also covers back-to-back lines and a reset in the middle of a line. These expose `done` arriving one cycle late and state left over after reset.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef enum logic [0:0] {
    VLS_IDLE = 1'b0,
    VLS_DRAW = 1'b1
  } vls_state_e;

endpackage

// File: rtl/vls_row_gen.sv
module vls_row_gen #(
  parameter int Y_W = 8,
  parameter int H_W = 8
) (
  input  logic           clk,
  input  logic           reset,
  input  logic           load,
  input  logic           step,
  input  logic [Y_W-1:0] y_in,
  input  logic [H_W-1:0] height,
  output logic [Y_W-1:0] row_q,
  output logic           single,
  output logic           at_last,
  output logic           near_last
);

  localparam logic [H_W-1:0] ONE_H = H_W'(1);

  logic [H_W-1:0] left_q;

  // pixels still to come after the current one
  assign single    = (height <= ONE_H);
  assign at_last   = (left_q == '0);
  assign near_last = (left_q == ONE_H);

  always_ff @(posedge clk) begin
    if (reset) begin
      row_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      row_q  <= y_in;
      left_q <= single ? '0 : height - ONE_H;
    end else if (step) begin
      row_q  <= row_q + 1'b1;
      left_q <= left_q - ONE_H;
    end
  end

endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
  import vls_pkg::*;
(
  input  logic clk,
  input  logic reset,
  input  logic start,
  input  logic single,
  input  logic at_last,
  input  logic near_last,
  output logic busy,
  output logic load,
  output logic step,
  output logic done
);

  vls_state_e state_q, state_d;
  logic       done_d;

  assign busy = (state_q == VLS_DRAW);
  assign load = (state_q == VLS_IDLE) && start;
  assign step = busy && !at_last;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      VLS_IDLE: if (start) begin
        state_d = VLS_DRAW;
        done_d  = single;
      end
      VLS_DRAW: if (at_last) begin
        state_d = VLS_IDLE;
      end else begin
        done_d = near_last;
      end
      default: state_d = VLS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (reset) begin
      state_q <= VLS_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

  // R5: done marks the pixel that the row counter reports as final
  a_r5_done_at_last: assert property (@(posedge clk) disable iff (reset)
    done |-> (busy && at_last));

  // R5: the final pixel is followed by an idle cycle
  a_r5_done_then_idle: assert property (@(posedge clk) disable iff (reset)
    done |=> (!busy && !done));

endmodule

// File: rtl/vline_seq.sv
module vline_seq #(
  parameter int X_W = 9,
  parameter int Y_W = 8,
  parameter int H_W = 8
) (
  input  logic           clk,
  input  logic           reset,
  input  logic           start,
  input  logic [X_W-1:0] x_in,
  input  logic [Y_W-1:0] y_in,
  input  logic [H_W-1:0] height,
  output logic [X_W-1:0] x_out,
  output logic [Y_W-1:0] y_out,
  output logic           done
);

  logic busy, load, step;
  logic single, at_last, near_last;
  logic [X_W-1:0] col_q;

  vls_ctrl u_ctrl (
    .clk       (clk),
    .reset     (reset),
    .start     (start),
    .single    (single),
    .at_last   (at_last),
    .near_last (near_last),
    .busy      (busy),
    .load      (load),
    .step      (step),
    .done      (done)
  );

  vls_row_gen #(.Y_W(Y_W), .H_W(H_W)) u_rows (
    .clk       (clk),
    .reset     (reset),
    .load      (load),
    .step      (step),
    .y_in      (y_in),
    .height    (height),
    .row_q     (y_out),
    .single    (single),
    .at_last   (at_last),
    .near_last (near_last)
  );

  always_ff @(posedge clk) begin
    if (reset)     col_q <= '0;
    else if (load) col_q <= x_in;
  end

  assign x_out = col_q;

  // R2: first pixel carries the sampled column and top row
  a_r2_first_pixel: assert property (@(posedge clk) disable iff (reset)
    (!busy && start) |=> (busy && x_out == $past(x_in) && y_out == $past(y_in)));

  // R3: column is steady within a line
  a_r3_col_steady: assert property (@(posedge clk) disable iff (reset)
    (busy && !done) |=> $stable(x_out));

  // R4, R8: row advances by one, wrapping
  a_r4_row_step: assert property (@(posedge clk) disable iff (reset)
    (busy && !done) |=> (y_out == Y_W'($past(y_out) + 1'b1)));

  // R6: zero or unit height yields an immediate done
  a_r6_single_pixel: assert property (@(posedge clk) disable iff (reset)
    (!busy && start && height <= H_W'(1)) |=> done);

  // R7: start during a line leaves the line running
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (reset)
    (busy && !done && start) |=> busy);

  // R10: idle outputs hold
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (reset)
    (!busy && !start) |=> ($stable(x_out) && $stable(y_out) && !done));

endmodule

// File: tb/vline_seq_tb_top.sv
module vline_seq_tb_top;

  logic       clk = 1'b0;
  logic       reset = 1'b1;
  logic       start = 1'b0;
  logic [8:0] x_in = '0;
  logic [7:0] y_in = '0;
  logic [7:0] height = '0;
  logic [8:0] x_out;
  logic [7:0] y_out;
  logic       done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  vline_seq dut_i (
    .clk(clk), .reset(reset), .start(start),
    .x_in(x_in), .y_in(y_in), .height(height),
    .x_out(x_out), .y_out(y_out), .done(done)
  );

  // behavioural reference: pixels remaining including the current one
  int  m_left = 0;
  int  m_x = 0;
  int  m_y = 0;
  bit  m_done = 0;

  always @(posedge clk) begin
    if (reset) begin
      m_left = 0; m_x = 0; m_y = 0; m_done = 0;
    end else if (m_left == 0) begin
      m_done = 0;
      if (start) begin
        m_x = x_in;
        m_y = y_in;
        m_left = (height == 0) ? 1 : height;
        m_done = (m_left == 1);
      end
    end else begin
      m_left = m_left - 1;
      if (m_left == 0) m_done = 0;
      else begin
        m_y = (m_y + 1) % 256;
        m_done = (m_left == 1);
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (x_out !== m_x[8:0] || y_out !== m_y[7:0] || done !== m_done) begin
        errors++;
        $display("FAIL %s model: got x=%0d y=%0d done=%0b expected x=%0d y=%0d done=%0b",
                 tag, x_out, y_out, done, m_x, m_y, m_done);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0 quiet, 1 start pulses with junk, 2 inputs changed mid-line
  task automatic run_line(input int x, input int y, input int h, input string req, input int mode);
    int n = (h == 0) ? 1 : h;
    tag = req;
    @(negedge clk);
    x_in = x[8:0]; y_in = y[7:0]; height = h[7:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      chk({req, " x"}, x_out, x);
      chk({req, " y"}, y_out, (y + k) % 256);
      chk({req, " done"}, done, (k == n - 1) ? 1 : 0);
      if (mode == 1) begin
        start = 1'b1; x_in = 9'd3; y_in = 8'd7; height = 8'd2;
      end else if (mode == 2) begin
        x_in = x_in + 9'd1; y_in = y_in + 8'd5; height = 8'd1;
      end
      if (k < n - 1) @(negedge clk);
    end
    @(negedge clk);
    start = 1'b0;
    chk({req, " R10 done low"}, done, 0);
    chk({req, " R10 x hold"}, x_out, x);
    chk({req, " R10 y hold"}, y_out, (y + n - 1) % 256);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 x", x_out, 0);
    chk("R1 y", y_out, 0);
    reset = 1'b0;
    @(negedge clk);
    chk("R1 idle", done, 0);

    run_line(100, 50, 6, "R2 R4 R5", 0);
    run_line(511, 0, 1, "R5 unit", 0);
    run_line(17, 200, 0, "R6", 0);
    run_line(40, 250, 10, "R8", 0);
    run_line(222, 30, 5, "R7", 1);
    @(negedge clk);
    chk("R7 stays idle", done, 0);
    run_line(60, 90, 4, "R9", 2);
    run_line(8, 12, 3, "R3", 0);
    run_line(9, 13, 2, "R10 back-to-back", 0);
    run_line(300, 1, 255, "R4 long", 0);

    // R1: reset during a line
    tag = "R1 mid";
    @(negedge clk);
    x_in = 9'd77; y_in = 8'd66; height = 8'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    reset = 1'b1;
    @(negedge clk);
    reset = 1'b0;
    chk("R1 mid x", x_out, 0);
    chk("R1 mid y", y_out, 0);
    chk("R1 mid done", done, 0);
    repeat (25) @(negedge clk);
    chk("R1 mid stays idle", done, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule